// File: doc/BRIEF.md
# Packed Signed Saturating Adder

This unit adds two 32-bit operands as packed vectors of signed integers. On each operation an input picks the lane layout: four 8-bit lanes or two 16-bit lanes. Every lane is a two's-complement sum of the matching slices of the two operands. No carry passes into a neighbouring lane, and a sum that leaves the signed range of its lane is pinned to the nearest end of that range, so a result never wraps.

A qualifying strobe marks each operation. One register stage later the packed result appears together with a per-lane "result is non-negative" flag vector. The unit can accept a new operation every cycle. A sticky flag records that some lane has been clamped since software last cleared it. The flag drops only through a dedicated clear input.

Top module: `psat_simd_add`

## Requirements
- R1: With `half_mode`=0 (byte layout) the operands are four signed 8-bit lanes, lane i in bits [8i+7:8i]. Result lane i is the signed sum of operand lanes i when that sum lies in range.
- R2: With `half_mode`=1 (halfword layout) the operands are two signed 16-bit lanes, lane h in bits [16h+15:16h]. Result lane h is the signed sum of operand lanes h when that sum lies in range.
- R3: A lane sum above the lane maximum yields the maximum (0x7F for bytes, 0x7FFF for halfwords). A lane sum below the minimum yields the minimum (0x80 for bytes, 0x8000 for halfwords).
- R4: No carry or borrow crosses a lane boundary in either layout. For example, byte lanes 0xFF+0x01 give 0x00 and leave the next lane unchanged.
- R5: `sat_sticky` goes to 1 on the clock edge that accepts a qualified operation in which at least one lane clamps. It then stays 1.
- R6: `sat_sticky` returns to 0 only on an edge where `sat_clear` is 1. If a clamping qualified operation is accepted on that same edge, the flag stays 1. An unqualified cycle (`in_valid`=0) never sets the flag.
- R7: In byte layout, `ge_flags[i]` is 1 exactly when result lane i is non-negative. In halfword layout, `ge_flags[2h+1:2h]` both equal 1 exactly when result lane h is non-negative.
- R8: `out_valid` equals `in_valid` delayed by one clock. `out_sum` and `ge_flags` update only on qualified operations and hold their values through unqualified cycles.
- R9: While `rst_n` is low, `out_valid`, `out_sum`, `ge_flags` and `sat_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the operands on this edge |
| half_mode | input | 1 | 0 = four byte lanes, 1 = two halfword lanes |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result registers hold a new result |
| out_sum | output | 32 | Packed saturated sum |
| sat_sticky | output | 1 | Some lane has clamped since the last clear |
| ge_flags | output | 4 | Per-lane non-negative result flags |

## Verification
The bench uses directed operands whose correct answers differ between the two layouts. A 0x00FF + 0x0001 slice gives 0x0000 in byte layout and 0x0100 in halfword layout, so a wrong mode decode or a carry that leaks across a lane boundary shows up. Other patterns push one lane past its maximum and a different lane past its minimum, leaving the remaining lanes in range. This shows that each lane clamps on its own and in the correct direction. Separate sequences exercise the sticky flag: a set, a hold through clean operations, a clear alone, and a clear on the same edge as a clamping operation. Unqualified cycles with garbage operands are mixed in, along with a long run of random operands, modes and clears, all compared against an integer model of the lane arithmetic.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int HALF_W     = 16;
  localparam int NUM_BYTES  = WORD_W / BYTE_W;
  localparam int NUM_HALVES = WORD_W / HALF_W;
  localparam int GE_REP     = NUM_BYTES / NUM_HALVES;

  typedef enum logic {
    LANES_BYTE = 1'b0,
    LANES_HALF = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         clamp_o,
  output logic         nonneg_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  // Returns {clamped, result}: sign-extend by one bit, add, pin on overflow.
  function automatic logic [W:0] sat_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] wide;
    wide = {x[W-1], x} + {y[W-1], y};
    if (wide[W] != wide[W-1]) begin
      return {1'b1, (wide[W] ? NEG_MIN : POS_MAX)};
    end
    return {1'b0, wide[W-1:0]};
  endfunction

  logic [W:0] lane_res;
  assign lane_res = sat_add(a_i, b_i);
  assign sum_o    = lane_res[W-1:0];
  assign clamp_o  = lane_res[W];
  assign nonneg_o = ~lane_res[W-1];

  // R3: a clamped lane sits on a range end, and only like-signed operands clamp
  always_comb begin
    if (clamp_o == 1'b1) begin
      p_clamp_bound_r3: assert (sum_o == POS_MAX || sum_o == NEG_MIN);
      p_clamp_signs_r3: assert (a_i[W-1] == b_i[W-1]);
    end
  end
endmodule

// File: rtl/psat_lane_array.sv
module psat_lane_array #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [WORD_W-1:0]        a_i,
  input  logic [WORD_W-1:0]        b_i,
  output logic [WORD_W-1:0]        sum_o,
  output logic [WORD_W/LANE_W-1:0] clamp_o,
  output logic [WORD_W/LANE_W-1:0] nonneg_o
);
  localparam int NL = WORD_W / LANE_W;

  // R4: each lane is a separate adder, so no carry path exists between lanes
  for (genvar g = 0; g < NL; g++) begin : g_lane
    psat_lane #(.W(LANE_W)) u_lane (
      .a_i      (a_i[g*LANE_W +: LANE_W]),
      .b_i      (b_i[g*LANE_W +: LANE_W]),
      .sum_o    (sum_o[g*LANE_W +: LANE_W]),
      .clamp_o  (clamp_o[g]),
      .nonneg_o (nonneg_o[g])
    );
  end
endmodule

// File: rtl/psat_merge.sv
module psat_merge
  import psat_pkg::*;
(
  input  lane_mode_e                mode_i,
  input  logic [WORD_W-1:0]         byte_sum_i,
  input  logic [NUM_BYTES-1:0]      byte_clamp_i,
  input  logic [NUM_BYTES-1:0]      byte_nonneg_i,
  input  logic [WORD_W-1:0]         half_sum_i,
  input  logic [NUM_HALVES-1:0]     half_clamp_i,
  input  logic [NUM_HALVES-1:0]     half_nonneg_i,
  output logic [WORD_W-1:0]         sum_o,
  output logic                      clamp_any_o,
  output logic [NUM_BYTES-1:0]      ge_o
);
  logic [NUM_BYTES-1:0] ge_half;

  // R7: in halfword layout each lane flag covers GE_REP flag bits
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_ge_rep
    assign ge_half[h*GE_REP +: GE_REP] = {GE_REP{half_nonneg_i[h]}};
  end

  always_comb begin
    if (mode_i == LANES_HALF) begin
      sum_o       = half_sum_i;
      clamp_any_o = |half_clamp_i;
      ge_o        = ge_half;
    end else begin
      sum_o       = byte_sum_i;
      clamp_any_o = |byte_clamp_i;
      ge_o        = byte_nonneg_i;
    end
  end
endmodule

// File: rtl/psat_simd_add.sv
module psat_simd_add
  import psat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 half_mode,
  input  logic [WORD_W-1:0]    opnd_a,
  input  logic [WORD_W-1:0]    opnd_b,
  input  logic                 sat_clear,
  output logic                 out_valid,
  output logic [WORD_W-1:0]    out_sum,
  output logic                 sat_sticky,
  output logic [NUM_BYTES-1:0] ge_flags
);
  lane_mode_e mode;
  assign mode = lane_mode_e'(half_mode);

  logic [WORD_W-1:0]     byte_sum,    half_sum;
  logic [NUM_BYTES-1:0]  byte_clamp,  byte_nonneg;
  logic [NUM_HALVES-1:0] half_clamp,  half_nonneg;

  // Named internal events for the assertions
  logic [WORD_W-1:0]    merged_sum;
  logic [NUM_BYTES-1:0] merged_ge;
  logic                 lane_clamp_any;
  logic                 clamp_event;
  lane_mode_e           mode_q;

  psat_lane_array #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_bytes (
    .a_i(opnd_a), .b_i(opnd_b),
    .sum_o(byte_sum), .clamp_o(byte_clamp), .nonneg_o(byte_nonneg)
  );

  psat_lane_array #(.WORD_W(WORD_W), .LANE_W(HALF_W)) u_halves (
    .a_i(opnd_a), .b_i(opnd_b),
    .sum_o(half_sum), .clamp_o(half_clamp), .nonneg_o(half_nonneg)
  );

  psat_merge u_merge (
    .mode_i        (mode),
    .byte_sum_i    (byte_sum),
    .byte_clamp_i  (byte_clamp),
    .byte_nonneg_i (byte_nonneg),
    .half_sum_i    (half_sum),
    .half_clamp_i  (half_clamp),
    .half_nonneg_i (half_nonneg),
    .sum_o         (merged_sum),
    .clamp_any_o   (lane_clamp_any),
    .ge_o          (merged_ge)
  );

  assign clamp_event = in_valid & lane_clamp_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sum    <= '0;
      ge_flags   <= '0;
      sat_sticky <= 1'b0;
      mode_q     <= LANES_BYTE;
    end else begin
      out_valid  <= in_valid;
      sat_sticky <= (sat_sticky & ~sat_clear) | clamp_event;
      if (in_valid) begin
        out_sum  <= merged_sum;
        ge_flags <= merged_ge;
        mode_q   <= mode;
      end
    end
  end

  // R8: result strobe trails the input strobe by one edge
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R8: idle cycles leave the result registers untouched
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sum) && $stable(ge_flags)));

  // R5: a clamping qualified operation sets the sticky flag
  p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_event |=> sat_sticky);

  // R6: without clear the flag never falls; without a clamp it never rises
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_clear && !clamp_event) |=> $stable(sat_sticky));

  // R6: a clear alone drops the flag
  p_sticky_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clear && !clamp_event) |=> !sat_sticky);

  // R7: flags agree with the sign bits of the registered result
  p_ge_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == LANES_BYTE) |->
      (ge_flags == ~{out_sum[31], out_sum[23], out_sum[15], out_sum[7]}));

  p_ge_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == LANES_HALF) |->
      (ge_flags == {{2{~out_sum[31]}}, {2{~out_sum[15]}}}));
endmodule

// File: tb/psat_simd_add_test.sv
module psat_simd_add_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        half_mode = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        sat_clear = 1'b0;
  logic        out_valid;
  logic [31:0] out_sum;
  logic        sat_sticky;
  logic [3:0]  ge_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  psat_simd_add uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clear(sat_clear),
    .out_valid(out_valid), .out_sum(out_sum), .sat_sticky(sat_sticky),
    .ge_flags(ge_flags)
  );

  typedef struct packed {
    logic        vld;
    logic [31:0] sum;
    logic [3:0]  ge;
    logic        stk;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  logic  model_sticky = 1'b0;
  logic [31:0] last_sum = '0;
  logic [3:0]  last_ge  = '0;
  bit    done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int slice_signed(input logic [31:0] v, input int pos, input int w);
    int u;
    u = int'((v >> pos) & ((32'd1 << w) - 1));
    if (u >= (1 << (w-1))) u = u - (1 << w);
    return u;
  endfunction

  function automatic int pin(input int s, input int w);
    int hi, lo;
    hi = (1 << (w-1)) - 1;
    lo = -(1 << (w-1));
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  // Driver: applies one cycle of stimulus and queues what must appear after the edge
  task automatic issue(input logic vld, input logic hm, input logic [31:0] a,
                       input logic [31:0] b, input logic clr, input string tag);
    exp_t e;
    int w, n, x, y, r;
    logic any_clamp;
    logic [31:0] s;
    logic [3:0]  g;
    @(negedge clk);
    in_valid = vld; half_mode = hm; opnd_a = a; opnd_b = b; sat_clear = clr;
    w = hm ? 16 : 8;
    n = 32 / w;
    s = '0; g = '0; any_clamp = 1'b0;
    for (int i = 0; i < n; i++) begin
      x = slice_signed(a, i*w, w);
      y = slice_signed(b, i*w, w);
      r = pin(x + y, w);
      if (r != x + y) any_clamp = 1'b1;
      s = s | ((32'(r) & ((32'd1 << w) - 1)) << (i*w));
      for (int k = 0; k < w/8; k++) g[i*(w/8)+k] = (r >= 0);
    end
    model_sticky = (model_sticky & ~clr) | (vld & any_clamp);
    if (vld) begin
      last_sum = s;
      last_ge  = g;
    end
    e.vld = vld; e.sum = last_sum; e.ge = last_ge; e.stk = model_sticky;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one queued item per cycle, just after the edge
  always begin
    exp_t e;
    string t;
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " R8 out_valid"}, 32'(out_valid), 32'(e.vld));
      check({t, " R5/R6 sticky R5 R6"}, 32'(sat_sticky), 32'(e.stk));
      check({t, " sum"}, out_sum, e.sum);
      check({t, " R7 ge_flags"}, 32'(ge_flags), 32'(e.ge));
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset out_valid", 32'(out_valid), 32'd0);
    check("R9 reset out_sum", out_sum, 32'd0);
    check("R9 reset sticky", 32'(sat_sticky), 32'd0);
    check("R9 reset ge_flags", 32'(ge_flags), 32'd0);
    rst_n = 1'b1;

    // R1: plain byte sums, no clamping
    issue(1, 0, 32'h01020304, 32'h10203040, 0, "R1 byte plain");
    issue(1, 0, 32'hF0FE7001, 32'h0501F002, 0, "R1 byte mixed signs");
    // R4: lane boundary, byte layout: 0xFF+0x01 lanes give 0x00, no carry out
    issue(1, 0, 32'h00FF00FF, 32'h00010001, 0, "R4 byte boundary");
    // R2: halfword sums, and the same operands read as halfwords
    issue(1, 1, 32'h00FF00FF, 32'h00010001, 0, "R2/R4 half boundary");
    issue(1, 1, 32'h12345678, 32'h11111111, 0, "R2 half plain");
    // R8: idle cycle with garbage operands holds result and sticky
    issue(0, 0, 32'h7F7F7F7F, 32'h7F7F7F7F, 0, "R8 idle no effect R6");
    // R3: byte clamps both ways, other lanes in range
    issue(1, 0, 32'h1080507F, 32'h10FF5001, 0, "R3 byte clamp R5");
    // R6: sticky holds through clean ops
    issue(1, 0, 32'h01010101, 32'h01010101, 0, "R6 hold");
    issue(0, 0, 32'h0, 32'h0, 1, "R6 clear alone");
    issue(1, 1, 32'h7FFF0001, 32'h00010002, 0, "R3 half pos clamp R5");
    issue(1, 1, 32'h80000100, 32'hFFFF0100, 1, "R3 half neg clamp R6 set wins");
    issue(1, 1, 32'h00010001, 32'h00010001, 1, "R6 clear with clean op");
    issue(1, 1, 32'hFFFF8000, 32'h0000FFFF, 0, "R3 half min clamp");
    issue(1, 0, 32'h80808080, 32'h80808080, 1, "R3 byte all min R6");

    // Random stream, mixed layouts, idles and clears
    for (int i = 0; i < 400; i++) begin
      logic v, hm, c;
      string tg;
      v  = ($urandom_range(0, 3) != 0);
      hm = 1'($urandom_range(0, 1));
      c  = ($urandom_range(0, 7) == 0);
      tg = hm ? "R2 random" : "R1 random";
      issue(v, hm, $urandom, $urandom, c, tg);
    end

    issue(0, 0, 32'h0, 32'h0, 0, "R8 flush");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule